// File: doc/BRIEF.md
# Byte-wide GPIO port with per-pin interrupt detection

This block is one 8-bit general-purpose I/O port sitting on a simple byte-wide register bus. Each pin is either driven from a data register or sampled as an input. The direction register selects which. Input pins pass through a two-flop synchronizer. When filtering is enabled for a pin, its input then passes through a stability filter.

Every pin can act as an interrupt source. Software picks level or edge detection for the pin and picks the active sense: high or rising, or low or falling. A level source reports while its condition holds. An edge source sets a sticky pending bit that stays until software writes a one to that position of the acknowledge register. Changing a pin's mode or sense discards any stale pending edge on that pin. The port drives one interrupt line per pin and a combined line, and its pending bits can be read back over the bus.

The bus has no wait states. A write takes effect at the clock edge where `bus_sel` and `bus_we` are high. Read data is combinational from `bus_addr` while `bus_sel` is high.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0x00, `pin_oe` is 0x00, `pin_out` is 0x00 and both interrupt outputs are low.
- R2: Writes go to byte offsets 0x00 (output data), 0x10 (direction, where 1 means output), 0x90 (mode, where 0 means level and 1 means edge), 0x94 (sense, where 0 means low or falling and 1 means high or rising), 0x98 (acknowledge), 0x9C (interrupt enable) and 0xA8 (filter enable). Each of these except the acknowledge register reads back the value last written. Offset 0xA0 reads the pending status, where bit i is pin i. The acknowledge offset and unmapped offsets read 0x00.
- R3: `pin_oe` equals the direction register and `pin_out` equals the output data register. A read of offset 0x00 returns the data register bit for output pins and the synchronized pin level for input pins.
- R4: In level mode, a pin's status bit is 1 while the pin is enabled and its qualified input equals its sense bit. The bit is not latched, so it falls when the condition ends.
- R5: In edge mode, an enabled pin sets its status bit on a transition of its qualified input in the direction selected by the sense bit. The bit stays set through later input changes.
- R6: Writing the acknowledge register clears the pending edge for each position written as 1. Positions written as 0 keep their pending edge. If a new edge arrives in the same cycle as the acknowledge, the edge wins.
- R7: A pin whose enable bit is 0 has a status bit of 0 and latches no edge. Enabling such a pin later does not reveal an edge that happened while it was disabled.
- R8: A write to the mode or sense register that changes a pin's bit clears that pin's pending edge. Pins whose bits are unchanged keep their pending edge.
- R9: With filtering enabled, a new synchronized level reaches detection only after it has differed from the current filtered level on DEB_CYCLES consecutive clocks (default 4). Shorter pulses are ignored. With filtering disabled, a one-clock pulse is detected.
- R10: `irq_pin` bit i equals status bit i, and `irq_any` is high exactly when some status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Driven pin levels |
| pin_oe | output | 8 | Output enable per pin |
| irq_pin | output | 8 | Interrupt per pin |
| irq_any | output | 1 | OR of all pin interrupts |

## Verification
Every pin is taken through all four mode and sense pairs. Each pair sees the same low, high, low, acknowledge input sequence. This separates level from edge, shows a level bit falling while an edge bit holds, and shows which sense reacts to which transition. Data reads are swept over several direction masks with opposing data and pin patterns, so inputs and driven values cannot be confused. The acknowledge and reconfiguration tests run with two pins pending at once, so one write can be shown to clear one pin and keep the other. A pulse-length sweep from one to six clocks, with and without filtering, finds the exact length at which the filter starts to pass a level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_FILTER = 8'hA8;

  // true when a level input is in its active state
  function automatic logic level_active(input logic lvl, input logic sense);
    return lvl == sense;
  endfunction

  // true when cur/prev form a transition in the chosen direction
  function automatic logic edge_seen(input logic cur, input logic prev, input logic sense);
    return sense ? (cur & ~prev) : (~cur & prev);
  endfunction

  // merge driven bits with sampled bits by direction
  function automatic logic [PORT_W-1:0] port_view(input logic [PORT_W-1:0] drv,
                                                  input logic [PORT_W-1:0] smp,
                                                  input logic [PORT_W-1:0] dir);
    return (drv & dir) | (smp & ~dir);
  endfunction
endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int DEB_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic filt_en_i,
  output logic sync_o,
  output logic qual_o
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic meta_q, sync_q, filt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!filt_en_i || (sync_q == filt_q)) begin
      filt_q <= sync_q;
      cnt_q  <= '0;
    end else if (cnt_q == CNT_LAST) begin
      filt_q <= sync_q;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sync_o = sync_q;
  assign qual_o = filt_en_i ? filt_q : sync_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic qual_i,
  input  logic is_edge_i,
  input  logic sense_i,
  input  logic enable_i,
  input  logic ack_i,
  input  logic cfg_chg_i,
  output logic edge_evt_o,
  output logic latch_o,
  output logic status_o
);
  logic prev_q, latch_q;

  assign edge_evt_o = enable_i & is_edge_i & edge_seen(qual_i, prev_q, sense_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= qual_i;
      if (cfg_chg_i || !is_edge_i) latch_q <= 1'b0;
      else if (edge_evt_o)         latch_q <= 1'b1;
      else if (ack_i)              latch_q <= 1'b0;
    end
  end

  assign latch_o  = latch_q;
  assign status_o = enable_i & (is_edge_i ? latch_q : level_active(qual_i, sense_i));
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic [PORT_W-1:0] sync_i,
  input  logic [PORT_W-1:0] status_i,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] data_o,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] mode_o,
  output logic [PORT_W-1:0] sense_o,
  output logic [PORT_W-1:0] enable_o,
  output logic [PORT_W-1:0] filter_o,
  output logic [PORT_W-1:0] ack_o,
  output logic [PORT_W-1:0] cfg_chg_o
);
  logic wr;
  logic [PORT_W-1:0] data_q, dir_q, mode_q, sense_q, en_q, filt_q;

  assign wr = bus_sel & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      mode_q  <= '0;
      sense_q <= '0;
      en_q    <= '0;
      filt_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_DATA:   data_q  <= bus_wdata;
        OFS_DIR:    dir_q   <= bus_wdata;
        OFS_MODE:   mode_q  <= bus_wdata;
        OFS_SENSE:  sense_q <= bus_wdata;
        OFS_ENABLE: en_q    <= bus_wdata;
        OFS_FILTER: filt_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    ack_o     = '0;
    cfg_chg_o = '0;
    if (wr) begin
      if (bus_addr == OFS_ACK)   ack_o     = bus_wdata;
      if (bus_addr == OFS_MODE)  cfg_chg_o = bus_wdata ^ mode_q;
      if (bus_addr == OFS_SENSE) cfg_chg_o = bus_wdata ^ sense_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_DATA:   bus_rdata = port_view(data_q, sync_i, dir_q);
        OFS_DIR:    bus_rdata = dir_q;
        OFS_MODE:   bus_rdata = mode_q;
        OFS_SENSE:  bus_rdata = sense_q;
        OFS_ENABLE: bus_rdata = en_q;
        OFS_FILTER: bus_rdata = filt_q;
        OFS_STATUS: bus_rdata = status_i;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign data_o   = data_q;
  assign dir_o    = dir_q;
  assign mode_o   = mode_q;
  assign sense_o  = sense_q;
  assign enable_o = en_q;
  assign filter_o = filt_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int DEB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic [PORT_W-1:0] irq_pin,
  output logic              irq_any
);
  logic [PORT_W-1:0] data_w, dir_w, mode_w, sense_w, en_w, filt_w;
  logic [PORT_W-1:0] ack_w, cfg_chg_w, sync_w, qual_w;
  logic [PORT_W-1:0] edge_evt_w, latch_w, status_w;

  gpio_irq_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sync_i    (sync_w),
    .status_i  (status_w),
    .bus_rdata (bus_rdata),
    .data_o    (data_w),
    .dir_o     (dir_w),
    .mode_o    (mode_w),
    .sense_o   (sense_w),
    .enable_o  (en_w),
    .filter_o  (filt_w),
    .ack_o     (ack_w),
    .cfg_chg_o (cfg_chg_w)
  );

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    gpio_pin_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_i     (pin_in[i]),
      .filt_en_i (filt_w[i]),
      .sync_o    (sync_w[i]),
      .qual_o    (qual_w[i])
    );
    gpio_pin_detect u_det (
      .clk        (clk),
      .rst_n      (rst_n),
      .qual_i     (qual_w[i]),
      .is_edge_i  (mode_w[i]),
      .sense_i    (sense_w[i]),
      .enable_i   (en_w[i]),
      .ack_i      (ack_w[i]),
      .cfg_chg_i  (cfg_chg_w[i]),
      .edge_evt_o (edge_evt_w[i]),
      .latch_o    (latch_w[i]),
      .status_o   (status_w[i])
    );
  end

  assign pin_out = data_w;
  assign pin_oe  = dir_w;
  assign irq_pin = status_w;
  assign irq_any = |status_w;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] irq_pin,
  input logic         irq_any,
  input logic [W-1:0] en_w,
  input logic [W-1:0] mode_w,
  input logic [W-1:0] ack_w,
  input logic [W-1:0] cfg_chg_w,
  input logic [W-1:0] edge_evt_w,
  input logic [W-1:0] latch_w
);
  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ~en_w) == '0);

  // R10
  combined_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_pin != '0));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w & ~edge_evt_w) != '0 |=> (latch_w & $past(ack_w & ~edge_evt_w)) == '0);

  // R5
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_w & ~ack_w & ~cfg_chg_w & mode_w) != '0 |=>
      (($past(latch_w & ~ack_w & ~cfg_chg_w & mode_w)) & ~latch_w) == '0);

  // R8
  cfg_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg_w != '0 |=> (latch_w & $past(cfg_chg_w)) == '0);

  // R4
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_w & ~mode_w) == '0);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.W(gpio_irq_pkg::PORT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_pin    (irq_pin),
  .irq_any    (irq_any),
  .en_w       (en_w),
  .mode_w     (mode_w),
  .ack_w      (ack_w),
  .cfg_chg_w  (cfg_chg_w),
  .edge_evt_w (edge_evt_w),
  .latch_w    (latch_w)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, pin_in = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe, irq_pin;
  logic       irq_any;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_pin(irq_pin), .irq_any(irq_any)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive pin p high for len clocks, then low again
  task automatic pulse(input int p, input int len);
    @(negedge clk); pin_in[p] = 1'b1;
    repeat (len) @(negedge clk);
    pin_in[p] = 1'b0;
    idle(12);
  endtask

  function automatic logic [7:0] any8(input logic [7:0] v);
    return {7'b0, |v};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] regs [6];
    logic [7:0] ofs [6];
    logic [7:0] dirs [4];
    ofs = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h9C, 8'hA8};
    dirs = '{8'h00, 8'hFF, 8'h0F, 8'h3C};

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int k = 0; k < 6; k++) begin rd(ofs[k], v); check("R1 reg", v, 8'h00); end
    rd(8'hA0, v); check("R1 status", v, 8'h00);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    check("R1 irq", irq_pin, 8'h00);
    check("R1 any", {7'b0, irq_any}, 8'h00);

    // R2 readback of config registers, ack and holes read zero
    regs = '{8'h00, 8'h00, 8'h6B, 8'hD2, 8'h00, 8'h99};
    for (int k = 2; k < 6; k++) if (k != 4) wr(ofs[k], regs[k]);
    for (int k = 2; k < 6; k++) if (k != 4) begin rd(ofs[k], v); check("R2 readback", v, regs[k]); end
    rd(8'h98, v); check("R2 ack reads zero", v, 8'h00);
    rd(8'h04, v); check("R2 hole reads zero", v, 8'h00);
    wr(8'h90, 8'h00); wr(8'h94, 8'h00); wr(8'hA8, 8'h00);

    // R3 direction and data sweep
    pin_in = 8'h5A;
    wr(8'h00, 8'hA5);
    for (int k = 0; k < 4; k++) begin
      wr(8'h10, dirs[k]);
      idle(3);
      check("R3 oe", pin_oe, dirs[k]);
      check("R3 out", pin_out, 8'hA5);
      rd(8'h00, v);
      check("R3 data read", v, (8'hA5 & dirs[k]) | (8'h5A & ~dirs[k]));
    end
    wr(8'h10, 8'h00);
    pin_in = 8'h00;
    idle(4);

    // R4 R5 R6 R10: every pin through every mode/sense pair
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic ed, sn;
        logic [7:0] bit_p, exp;
        ed = m[1]; sn = m[0];
        bit_p = 8'h01 << p;
        pin_in = 8'h00; idle(4);
        wr(8'h90, ed ? bit_p : 8'h00);
        wr(8'h94, sn ? bit_p : 8'h00);
        wr(8'h9C, bit_p);
        wr(8'h98, 8'hFF);
        idle(2);
        exp = (!ed && !sn) ? bit_p : 8'h00;
        check(ed ? "R5 idle low" : "R4 idle low", irq_pin, exp);
        check("R10 any", {7'b0, irq_any}, any8(exp));
        pin_in[p] = 1'b1; idle(6);
        exp = sn ? bit_p : 8'h00;
        check(ed ? "R5 after rise" : "R4 held high", irq_pin, exp);
        check("R10 any", {7'b0, irq_any}, any8(exp));
        pin_in[p] = 1'b0; idle(6);
        exp = (ed || !sn) ? bit_p : 8'h00;
        check(ed ? "R5 sticky after fall" : "R4 follows low", irq_pin, exp);
        wr(8'h98, bit_p); idle(2);
        exp = (!ed && !sn) ? bit_p : 8'h00;
        check(ed ? "R6 ack clears" : "R4 ack no effect", irq_pin, exp);
        rd(8'hA0, v);
        check("R2 status read", v, exp);
      end
    end
    wr(8'h9C, 8'h00);

    // R6 zeros keep pending; R8 config change clears only changed bit
    wr(8'h90, 8'h03); wr(8'h94, 8'h03); wr(8'h9C, 8'h03); wr(8'h98, 8'hFF);
    pin_in[0] = 1'b1; pin_in[1] = 1'b1; idle(6);
    check("R5 two pending", irq_pin, 8'h03);
    wr(8'h98, 8'h01); idle(1);
    check("R6 zero bit kept", irq_pin, 8'h02);
    pin_in = 8'h00; idle(6);
    pin_in[0] = 1'b1; idle(6);
    check("R5 both pending again", irq_pin, 8'h03);
    wr(8'h94, 8'h02); idle(1);
    check("R8 sense change clears pin0 only", irq_pin, 8'h02);
    wr(8'h94, 8'h02); idle(1);
    check("R8 same value keeps", irq_pin, 8'h02);
    wr(8'h90, 8'h01); idle(1);
    check("R8 mode change to level", irq_pin, 8'h00);
    pin_in = 8'h00; wr(8'h9C, 8'h00); idle(4);

    // R7 edges while disabled are lost
    wr(8'h90, 8'h10); wr(8'h94, 8'h10); wr(8'h98, 8'hFF);
    pin_in[4] = 1'b1; idle(6);
    check("R7 disabled no irq", irq_pin, 8'h00);
    wr(8'h9C, 8'h10); idle(2);
    check("R7 no hidden edge", irq_pin, 8'h00);
    wr(8'h94, 8'h00); idle(1);
    pin_in[4] = 1'b0; idle(6);
    check("R7 enabled detects", irq_pin, 8'h10);
    wr(8'h9C, 8'h00); idle(1);
    check("R7 disable masks", irq_pin, 8'h00);

    // R9 pulse length sweep, with and without filter
    wr(8'h90, 8'h08); wr(8'h94, 8'h08); wr(8'h9C, 8'h08);
    for (int f = 0; f < 2; f++) begin
      wr(8'hA8, f ? 8'h08 : 8'h00);
      for (int len = 1; len <= 6; len++) begin
        wr(8'h98, 8'hFF); idle(1);
        pulse(3, len);
        check(f ? "R9 filtered pulse" : "R9 unfiltered pulse", irq_pin,
              (!f || len >= 4) ? 8'h08 : 8'h00);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule